// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers up to thirty-two event lines into one interrupt request for a processor. Each implemented event line latches into a pending-status bit when it rises. Software reads the pending bits at any time to poll, whatever the enable settings are. A separate enable register picks which pending bits may raise the interrupt. A third view shows only the pending bits that are enabled. Software removes pending bits by writing ones to the status view. It can also inject interrupts by writing ones to the enabled view, which sets the matching pending bits as though their sources had fired.

The register port is a plain single-cycle port. A word address selects one of three registers. A write strobe commits the write data on the clock edge. Read data follows the address combinationally. The interrupt request is the OR of all enabled pending bits, taken through one register.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register, the enable register and `irqOut` are all zero, and so the cause view reads zero.
- R2: A 0-to-1 transition of an implemented `eventIn` bit sets the matching status bit at the next clock edge. A line held high sets its bit only once: after software clears the bit, it stays clear while the line stays high.
- R3: Reading address 0 returns every pending status bit, whatever the enable register holds.
- R4: Writing address 0 clears each status bit whose written bit is 1. Status bits written with 0 keep their value.
- R5: Reading address 1 returns the status bits ANDed with the enable register.
- R6: Writing address 1 sets each status bit whose written bit is 1 and leaves the other bits unchanged.
- R7: Address 2 is the enable register and reads back what was written. A 1 lets the matching pending bit reach the interrupt request, and a 0 blocks it.
- R8: `irqOut` goes high one clock edge after any enabled pending bit exists, and goes low one edge after none remains.
- R9: When a rising event and a status-clear write hit the same bit on the same edge, the bit ends up set.
- R10: The implemented bit positions are 31 and 30 (single-bit and multi-bit memory-correction events), 23 and 22 (protection-unit read and write violations), 21 to 17 (second serial port), 15 to 11 (first serial port) and 9 to 0 (external lines). That mask is 0xC0FEFBFF. Bits 29 to 24, 16 and 10 always read 0 and ignore writes and events. Address 3 reads as 0 and writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, sampled on the clock edge |
| wrEn | input | 1 | Write strobe for the addressed register |
| regAddr | input | 2 | Word address: 0 status, 1 cause, 2 enable, 3 unused |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr`, combinational |
| eventIn | input | 32 | Event lines, rising-edge detected |
| irqOut | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check the following properties. Reserved positions read zero. The interrupt request follows the enabled pending bits one edge later. A status bit never falls without a status write. A cause write leaves its bits set. An enable write lands masked to the implemented bits. A status write with no events present clears every written bit. Only the bench scenarios can show edge-versus-level behaviour on a held line, the result of a clear and an event on the same bit and edge, and polling with the enables off. They also check the exact one-cycle delay of the request, measured from the stimulus, and the address 3 behaviour.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    clrStatus;
    logic    setStatus;
    logic    loadEnable;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_ctl_control.sv
module irq_ctl_control
  import irq_ctl_pkg::*;
(
  input  logic              wrEn,
  input  logic [REG_AW-1:0] regAddr,
  output ctlStrobe_t        strb
);

  regSel_e sel;

  always_comb begin
    case (regAddr)
      2'd0:    sel = SEL_STATUS;
      2'd1:    sel = SEL_CAUSE;
      2'd2:    sel = SEL_ENABLE;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.rdSel      = sel;
    strb.clrStatus  = wrEn && (sel == SEL_STATUS);
    strb.setStatus  = wrEn && (sel == SEL_CAUSE);
    strb.loadEnable = wrEn && (sel == SEL_ENABLE);
  end

endmodule

// File: rtl/irq_ctl_datapath.sv
module irq_ctl_datapath
  import irq_ctl_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hC0FE_FBFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] eventIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] enableQ
);

  logic [DATA_W-1:0] eventPrev;
  logic [DATA_W-1:0] riseVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] statusNext;
  logic [DATA_W-1:0] causeVec;

  // Rising-edge detect; a new event takes precedence over a clear (R9)
  always_comb begin
    riseVec    = eventIn & ~eventPrev;
    clrVec     = strb.clrStatus ? wrData : '0;
    setVec     = strb.setStatus ? wrData : '0;
    statusNext = ((statusQ & ~clrVec) | setVec | riseVec) & IMPL_MASK;
    causeVec   = statusQ & enableQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventPrev <= '0;
      statusQ   <= '0;
      enableQ   <= '0;
      irqOut    <= 1'b0;
    end else begin
      eventPrev <= eventIn;
      statusQ   <= statusNext;
      if (strb.loadEnable) enableQ <= wrData & IMPL_MASK;
      irqOut    <= |causeVec;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STATUS: rdData = statusQ;
      SEL_CAUSE:  rdData = causeVec;
      SEL_ENABLE: rdData = enableQ;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hC0FE_FBFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] eventIn,
  output logic              irqOut
);

  ctlStrobe_t        strb;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] enableQ;

  irq_ctl_control ctl_i (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_ctl_datapath #(
    .DATA_W    (DATA_W),
    .IMPL_MASK (IMPL_MASK)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .eventIn (eventIn),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .statusQ (statusQ),
    .enableQ (enableQ)
  );

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hC0FE_FBFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] eventIn,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ
);

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~IMPL_MASK) == '0);

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & enableQ)) |=> irqOut);

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusQ & enableQ)) |=> !irqOut);

  p_sticky_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == 2'd0) |=> (($past(statusQ) & ~statusQ) == '0));

  p_force_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd1) |=>
      ((statusQ & $past(wrData) & IMPL_MASK) == ($past(wrData) & IMPL_MASK)));

  p_enable_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd2) |=> (enableQ == ($past(wrData) & IMPL_MASK)));

  p_clear_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd0 && eventIn == '0) |=> ((statusQ & $past(wrData)) == '0));

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .DATA_W    (DATA_W),
  .IMPL_MASK (IMPL_MASK)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .regAddr (regAddr),
  .wrData  (wrData),
  .eventIn (eventIn),
  .rdData  (rdData),
  .irqOut  (irqOut),
  .statusQ (statusQ),
  .enableQ (enableQ)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;

  localparam logic [31:0] IMPL = 32'hC0FE_FBFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] eventIn = '0;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_status_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .eventIn(eventIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    eventIn = v;
    @(negedge clk);
    eventIn = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    readReg(2'd0, v); check("R1 status", v, '0);
    readReg(2'd2, v); check("R1 enable", v, '0);
    readReg(2'd1, v); check("R1 cause", v, '0);
    check("R1 irq", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_poll;
    logic [31:0] v;
    pulse(32'h8000_0001);
    readReg(2'd0, v); check("R2/R3 status polled", v, 32'h8000_0001);
    readReg(2'd1, v); check("R5 cause masked off", v, '0);
    @(negedge clk);
    check("R8 irq blocked by enable", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    doWrite(2'd0, 32'h0000_0001);
    readReg(2'd0, v); check("R4 partial clear", v, 32'h8000_0000);
    doWrite(2'd0, 32'h8000_0000);
    readReg(2'd0, v); check("R4 full clear", v, '0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); eventIn = 32'h0000_0020;
    @(negedge clk);
    readReg(2'd0, v); check("R2 rise sets", v, 32'h0000_0020);
    doWrite(2'd0, 32'h0000_0020);
    @(negedge clk);
    readReg(2'd0, v); check("R2 held level no re-set", v, '0);
    eventIn = '0;
    @(negedge clk);
  endtask

  task automatic t_enable_irq;
    logic [31:0] v;
    doWrite(2'd2, 32'hFFFF_FFFF);
    readReg(2'd2, v); check("R7/R10 enable readback", v, IMPL);
    pulse(32'h0000_0800);
    readReg(2'd1, v); check("R5 cause", v, 32'h0000_0800);
    check("R8 irq not yet", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    check("R8 irq one edge later", {31'd0, irqOut}, 32'd1);
    doWrite(2'd0, 32'h0000_0800);
    check("R8 irq still high", {31'd0, irqOut}, 32'd1);
    @(negedge clk);
    check("R8 irq drops", {31'd0, irqOut}, 32'd0);
    doWrite(2'd2, 32'h0000_0000);
    pulse(32'h0000_0002);
    @(negedge clk);
    check("R7 disabled blocks irq", {31'd0, irqOut}, 32'd0);
    doWrite(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_force;
    logic [31:0] v;
    doWrite(2'd2, 32'hFFFF_FFFF);
    doWrite(2'd1, 32'h0040_0000);
    readReg(2'd0, v); check("R6 forced status", v, 32'h0040_0000);
    @(negedge clk);
    check("R6 forced irq", {31'd0, irqOut}, 32'd1);
    doWrite(2'd1, 32'h0000_0004);
    readReg(2'd0, v); check("R6 set keeps others", v, 32'h0040_0004);
    doWrite(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    @(negedge clk);
    eventIn = 32'h0002_0000;
    regAddr = 2'd0; wrData = 32'h0002_0000; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; eventIn = '0;
    readReg(2'd0, v); check("R9 event beats clear", v, 32'h0002_0000);
    doWrite(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    pulse(32'h3F01_0400);
    readReg(2'd0, v); check("R10 reserved events ignored", v, '0);
    doWrite(2'd1, 32'hFFFF_FFFF);
    readReg(2'd0, v); check("R10 force masked to layout", v, IMPL);
    doWrite(2'd3, 32'hFFFF_FFFF);
    readReg(2'd3, v); check("R10 address 3 reads zero", v, '0);
    readReg(2'd2, v); check("R10 address 3 write no effect", v, IMPL);
    doWrite(2'd0, 32'hFFFF_FFFF);
    readReg(2'd0, v); check("R4 clear all", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_poll();
    t_w1c();
    t_level();
    t_enable_irq();
    t_force();
    t_collision();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule